// File: doc/BRIEF.md
# Sync Polarity Normalizer and Vertical Source Selector

This block sits at the front of a display deflection controller. It receives two synchronous sync inputs. One carries horizontal sync, or composite horizontal/vertical sync. The other carries a pure vertical sync. For each input the block works out whether the pulses are high-going or low-going, and it inverts the input where needed so that the signal passed downstream is always positive-going. It recovers a vertical sync from the composite input by integrating it, so that a wide vertical interval is recognised and narrow line pulses are not.

The block keeps three sticky presence flags: pulses on the vertical input, pulses on the composite input, and pulses of the extracted vertical. All three are cleared together by a one-cycle strobe. The vertical sync sent downstream comes from one of two sources: the extracted vertical or the vertical pin. Software can pick the source directly. In automatic mode the block picks it from the presence flags and holds whichever source arrived first.

Top module: `sync_front`

## Requirements
- R1: Each input has its own polarity flag, with 0 meaning positive and 1 meaning negative (`hpol_o` for the composite input, `vpol_o` for the vertical input). The flag is updated only when the raw input completes its 8th rising edge since reset or since the last update. At that point the flag becomes 1 if the input spent more cycles high than low during that window, and 0 otherwise. Between updates the flag holds its value.
- R2: `hsync_o` equals `hsync_i` XOR `hpol_o`, registered with one cycle of latency. A negative input therefore comes out with its pulses as high levels.
- R3: An up/down counter follows the normalised composite signal. It counts up while that signal is high and down while it is low, saturating at both ends. Extracted vertical sync is 1 when the counter exceeds `vx_thr_i`. Line pulses of ordinary width never assert it.
- R4: `hdet_o`, `vdet_o` and `vxdet_o` are set by a rising edge of, respectively, the normalised composite input, the normalised vertical input and the extracted vertical. Each flag stays set after its signal stops.
- R5: A 1 on `det_clr_i` clears all three flags on the next edge. The clear wins over a pulse in the same cycle, and the flags capture new pulses afterwards.
- R6: With `auto_sel_i` = 0, `src_sel_i` selects the source of `vsync_o`: 0 selects the extracted vertical and 1 selects the normalised vertical pin.
- R7: With `auto_sel_i` = 1, `src_sel_i` is ignored. If exactly one of `vdet_o` and `vxdet_o` is set, the source that flag belongs to is selected.
- R8: With `auto_sel_i` = 1, when both flags are set, or neither is, the current source is kept. The source that arrives first therefore stays selected.
- R9: After reset, all outputs are 0, both polarity flags are positive, and the source is the extracted vertical.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hsync_i | input | 1 | Horizontal or composite sync, either polarity |
| vsync_i | input | 1 | Pure vertical sync, either polarity |
| det_clr_i | input | 1 | One-cycle strobe that clears the presence flags |
| auto_sel_i | input | 1 | 1 selects the source automatically |
| src_sel_i | input | 1 | Manual source: 0 extracted, 1 vertical pin |
| vx_thr_i | input | EXT_W | Threshold of the extraction integrator |
| hsync_o | output | 1 | Normalised horizontal sync |
| vsync_o | output | 1 | Selected vertical sync |
| hpol_o | output | 1 | Composite input polarity (1 = negative) |
| vpol_o | output | 1 | Vertical input polarity (1 = negative) |
| hdet_o | output | 1 | Composite input pulses seen |
| vdet_o | output | 1 | Vertical input pulses seen |
| vxdet_o | output | 1 | Extracted vertical pulses seen |

## Verification
The hardest case to reach is the hold when both sources are present in automatic mode. To get there, the presence flags must be set in a known order. The stimulus clears the flags, presents one source alone until its flag latches and the selection follows it, and only then brings in the other source. The bench then counts the high cycles on `vsync_o` and checks that the output keeps following the first source and ignores the newcomer, for both arrival orders. The integrator threshold is also exercised from both sides: with the same composite frame, a low threshold yields an extracted pulse and a high one yields none.

// File: rtl/sync_front_pkg.sv
`timescale 1ns/1ps
package sync_front_pkg;
  typedef enum logic {SRC_EXTR = 1'b0, SRC_VPIN = 1'b1} vsrc_e;
  localparam int unsigned POL_WIN = 8;
endpackage

// File: rtl/sync_pol_norm.sv
`timescale 1ns/1ps
module sync_pol_norm #(
  parameter int unsigned WIN   = 8,
  parameter int unsigned CNT_W = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  output logic pol_o,
  output logic norm_o
);
  localparam int unsigned PW = (WIN > 1) ? $clog2(WIN) : 1;
  localparam logic [PW-1:0] LAST = PW'(WIN - 1);

  logic             in_q, pol_q, norm_q;
  logic [PW-1:0]    per_q;
  logic [CNT_W-1:0] hi_q, lo_q;
  logic             rise, win_end;

  assign rise    = raw_i & ~in_q;
  assign win_end = rise && (per_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_q   <= 1'b0;
      pol_q  <= 1'b0;
      norm_q <= 1'b0;
      per_q  <= '0;
      hi_q   <= '0;
      lo_q   <= '0;
    end else begin
      in_q   <= raw_i;
      norm_q <= raw_i ^ pol_q;
      if (win_end) begin
        // more time high than low means the pulses are the low parts
        pol_q <= (hi_q > lo_q);
        per_q <= '0;
        hi_q  <= '0;
        lo_q  <= '0;
      end else begin
        if (rise) per_q <= per_q + 1'b1;
        if (raw_i) begin
          if (hi_q != '1) hi_q <= hi_q + 1'b1;
        end else begin
          if (lo_q != '1) lo_q <= lo_q + 1'b1;
        end
      end
    end
  end

  assign pol_o  = pol_q;
  assign norm_o = norm_q;

  p_pol_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !win_end |=> $stable(pol_q))
    else $error("polarity changed outside a window end");
endmodule

// File: rtl/sync_vext.sv
`timescale 1ns/1ps
module sync_vext #(
  parameter int unsigned CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sync_i,
  input  logic [CW-1:0] thr_i,
  output logic          vx_o
);
  logic [CW-1:0] cnt_q;
  logic          vx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      vx_q  <= 1'b0;
    end else begin
      if (sync_i) begin
        if (cnt_q != '1) cnt_q <= cnt_q + 1'b1;
      end else if (cnt_q != '0) begin
        cnt_q <= cnt_q - 1'b1;
      end
      vx_q <= (cnt_q > thr_i);
    end
  end

  assign vx_o = vx_q;

  p_vx_above_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q > thr_i) |=> vx_q)
    else $error("integrator above threshold without extracted vsync");
endmodule

// File: rtl/sync_vsrc_sel.sv
`timescale 1ns/1ps
module sync_vsrc_sel
  import sync_front_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hn_i,
  input  logic vn_i,
  input  logic vx_i,
  input  logic det_clr_i,
  input  logic auto_i,
  input  logic sel_i,
  output logic hdet_o,
  output logic vdet_o,
  output logic vxdet_o,
  output logic vsync_o
);
  logic  hn_q, vn_q, vx_q;
  logic  hdet_q, vdet_q, vxdet_q, vs_q;
  vsrc_e src_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hn_q    <= 1'b0;
      vn_q    <= 1'b0;
      vx_q    <= 1'b0;
      hdet_q  <= 1'b0;
      vdet_q  <= 1'b0;
      vxdet_q <= 1'b0;
      src_q   <= SRC_EXTR;
      vs_q    <= 1'b0;
    end else begin
      hn_q <= hn_i;
      vn_q <= vn_i;
      vx_q <= vx_i;
      if (det_clr_i) begin
        hdet_q  <= 1'b0;
        vdet_q  <= 1'b0;
        vxdet_q <= 1'b0;
      end else begin
        hdet_q  <= hdet_q  | (hn_i & ~hn_q);
        vdet_q  <= vdet_q  | (vn_i & ~vn_q);
        vxdet_q <= vxdet_q | (vx_i & ~vx_q);
      end
      if (!auto_i)                  src_q <= vsrc_e'(sel_i);
      else if (vdet_q && !vxdet_q)  src_q <= SRC_VPIN;
      else if (vxdet_q && !vdet_q)  src_q <= SRC_EXTR;
      vs_q <= (src_q == SRC_VPIN) ? vn_i : vx_i;
    end
  end

  assign hdet_o  = hdet_q;
  assign vdet_o  = vdet_q;
  assign vxdet_o = vxdet_q;
  assign vsync_o = vs_q;

  p_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hdet_q && !det_clr_i) |=> hdet_q)
    else $error("presence flag dropped without clear");

  p_clear_all_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    det_clr_i |=> (!hdet_q && !vdet_q && !vxdet_q))
    else $error("clear strobe left a flag set");

  p_manual_sel_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !auto_i |=> (src_q == vsrc_e'($past(sel_i))))
    else $error("manual select not followed");

  p_auto_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (auto_i && vdet_q && !vxdet_q) |=> (src_q == SRC_VPIN))
    else $error("auto mode did not take the only present source");

  p_auto_keep_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (auto_i && vdet_q && vxdet_q) |=> $stable(src_q))
    else $error("auto mode switched while both sources present");
endmodule

// File: rtl/sync_front.sv
`timescale 1ns/1ps
module sync_front #(
  parameter int unsigned POL_WIN   = sync_front_pkg::POL_WIN,
  parameter int unsigned POL_CNT_W = 16,
  parameter int unsigned EXT_W     = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hsync_i,
  input  logic             vsync_i,
  input  logic             det_clr_i,
  input  logic             auto_sel_i,
  input  logic             src_sel_i,
  input  logic [EXT_W-1:0] vx_thr_i,
  output logic             hsync_o,
  output logic             vsync_o,
  output logic             hpol_o,
  output logic             vpol_o,
  output logic             hdet_o,
  output logic             vdet_o,
  output logic             vxdet_o
);
  localparam int unsigned NCH = 2;  // index 0 composite, 1 vertical pin

  logic [NCH-1:0] raw, pol, norm;
  logic           vx;

  assign raw = {vsync_i, hsync_i};

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    sync_pol_norm #(.WIN(POL_WIN), .CNT_W(POL_CNT_W)) u_pn (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .raw_i  (raw[g]),
      .pol_o  (pol[g]),
      .norm_o (norm[g])
    );
  end

  sync_vext #(.CW(EXT_W)) u_vext (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sync_i (norm[0]),
    .thr_i  (vx_thr_i),
    .vx_o   (vx)
  );

  sync_vsrc_sel u_sel (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .hn_i      (norm[0]),
    .vn_i      (norm[1]),
    .vx_i      (vx),
    .det_clr_i (det_clr_i),
    .auto_i    (auto_sel_i),
    .sel_i     (src_sel_i),
    .hdet_o    (hdet_o),
    .vdet_o    (vdet_o),
    .vxdet_o   (vxdet_o),
    .vsync_o   (vsync_o)
  );

  assign hsync_o = norm[0];
  assign hpol_o  = pol[0];
  assign vpol_o  = pol[1];
endmodule

// File: tb/sim_sync_front.sv
`timescale 1ns/1ps
module sim_sync_front;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       hs = 1'b0, vs = 1'b0, clr = 1'b0, auto_s = 1'b0, sel = 1'b0;
  logic [7:0] thr = 8'd40;
  logic       hsync_o, vsync_o, hpol_o, vpol_o, hdet_o, vdet_o, vxdet_o;

  sync_front u0 (
    .clk_i(clk), .rst_ni(rst_n), .hsync_i(hs), .vsync_i(vs),
    .det_clr_i(clr), .auto_sel_i(auto_s), .src_sel_i(sel), .vx_thr_i(thr),
    .hsync_o(hsync_o), .vsync_o(vsync_o), .hpol_o(hpol_o), .vpol_o(vpol_o),
    .hdet_o(hdet_o), .vdet_o(vdet_o), .vxdet_o(vxdet_o)
  );

  always #5 clk = ~clk;

  int  n_chk = 0, n_fail = 0, n_hs = 0, n_vs = 0;
  bit  done = 1'b0;

  typedef struct {
    string req;
    string what;
    int    exp;
  } item_t;
  item_t q[$];
  event  chk_ev;

  function automatic int observe(string w);
    case (w)
      "hs":      return int'(hsync_o);
      "vs":      return int'(vsync_o);
      "hpol":    return int'(hpol_o);
      "vpol":    return int'(vpol_o);
      "hdet":    return int'(hdet_o);
      "vdet":    return int'(vdet_o);
      "vxdet":   return int'(vxdet_o);
      "n_hs":    return n_hs;
      "n_vs":    return n_vs;
      "vs_seen": return int'(n_vs > 0);
      default:   return -1;
    endcase
  endfunction

  // monitor: pops expected items and compares with what the design shows
  initial begin
    forever begin
      @(chk_ev);
      while (q.size() > 0) begin
        item_t it;
        int    act;
        it  = q.pop_front();
        act = observe(it.what);
        n_chk++;
        if (act != it.exp) begin
          n_fail++;
          $display("FAIL %s %s: actual %0d expected %0d", it.req, it.what, act, it.exp);
        end
      end
    end
  end

  task automatic expect_val(string req, string what, int exp);
    q.push_back('{req, what, exp});
    ->chk_ev;
    #1;
  endtask

  task automatic tick();
    @(negedge clk);
    if (hsync_o) n_hs++;
    if (vsync_o) n_vs++;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; hs = 1'b0; vs = 1'b0; clr = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
  endtask

  // 40-cycle lines, 4-cycle line pulse; vertical lines are inverted (wide)
  task automatic comp(int lines, int vstart, int vlen, bit neg);
    for (int l = 0; l < lines; l++) begin
      for (int c = 0; c < 40; c++) begin
        logic act;
        act = (l >= vstart && l < vstart + vlen) ? (c >= 4) : (c < 4);
        tick();
        hs = act ^ neg;
      end
    end
  endtask

  // 60-cycle periods, 6-cycle pulse
  task automatic vpin(int pulses, bit neg);
    for (int p = 0; p < pulses; p++) begin
      for (int c = 0; c < 60; c++) begin
        tick();
        vs = (c < 6) ^ neg;
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R9 reset state
    expect_val("R9", "hs", 0);
    expect_val("R9", "vs", 0);
    expect_val("R9", "hpol", 0);
    expect_val("R9", "vpol", 0);
    expect_val("R9", "hdet", 0);
    expect_val("R9", "vdet", 0);
    expect_val("R9", "vxdet", 0);

    // positive composite without vertical interval
    comp(12, 0, 0, 1'b0);
    expect_val("R1", "hpol", 0);
    n_hs = 0;
    comp(2, 0, 0, 1'b0);
    expect_val("R2", "n_hs", 8);
    expect_val("R4", "hdet", 1);
    expect_val("R4", "vdet", 0);
    expect_val("R3", "vxdet", 0);
    repeat (100) tick();
    expect_val("R4", "hdet", 1);
    tick(); clr = 1'b1;
    tick(); clr = 1'b0;
    repeat (3) tick();
    expect_val("R5", "hdet", 0);
    expect_val("R5", "vxdet", 0);
    comp(1, 0, 0, 1'b0);
    repeat (3) tick();
    expect_val("R5", "hdet", 1);

    // negative composite is normalised
    do_reset();
    comp(12, 0, 0, 1'b1);
    expect_val("R1", "hpol", 1);
    n_hs = 0;
    comp(2, 0, 0, 1'b1);
    expect_val("R2", "n_hs", 8);

    // negative vertical pin
    do_reset();
    vpin(10, 1'b1);
    expect_val("R1", "vpol", 1);
    expect_val("R1", "hpol", 0);

    // manual selection
    do_reset();
    sel = 1'b1;
    repeat (10) tick();
    n_vs = 0;
    vpin(5, 1'b0);
    expect_val("R6", "n_vs", 30);
    expect_val("R4", "vdet", 1);
    sel = 1'b0;
    repeat (5) tick();
    n_vs = 0;
    vpin(3, 1'b0);
    expect_val("R6", "n_vs", 0);
    n_vs = 0;
    comp(10, 2, 3, 1'b0);
    expect_val("R6", "vs_seen", 1);
    expect_val("R3", "vxdet", 1);

    // threshold above reachable count: no extraction
    do_reset();
    thr = 8'd200;
    n_vs = 0;
    comp(10, 2, 3, 1'b0);
    expect_val("R3", "vxdet", 0);
    expect_val("R3", "n_vs", 0);
    thr = 8'd40;

    // auto: pin first, select bit ignored
    do_reset();
    auto_s = 1'b1; sel = 1'b0;
    vpin(2, 1'b0);
    expect_val("R7", "vdet", 1);
    n_vs = 0;
    vpin(3, 1'b0);
    expect_val("R7", "n_vs", 18);
    n_vs = 0;
    comp(10, 2, 3, 1'b0);
    expect_val("R8", "vxdet", 1);
    expect_val("R8", "n_vs", 0);
    n_vs = 0;
    vpin(3, 1'b0);
    expect_val("R8", "n_vs", 18);

    // auto: extracted first, select bit set but ignored
    do_reset();
    sel = 1'b1;
    n_vs = 0;
    comp(10, 2, 3, 1'b0);
    expect_val("R7", "vs_seen", 1);
    expect_val("R7", "vdet", 0);
    n_vs = 0;
    vpin(3, 1'b0);
    expect_val("R8", "vdet", 1);
    expect_val("R8", "n_vs", 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule